// File: doc/BRIEF.md
# Two-Level Lookahead Adder (16 bits)

This block adds two 16-bit operands and a carry input in pure combinational logic, so the sum and carry output settle in the same cycle as the operands. Carry into every bit is found by lookahead rather than by a ripple chain. Each bit position makes a generate term (both operand bits set) and a propagate term (operand bits differ). A sum bit is the propagate term XOR the carry into that bit.

The sixteen bits form four groups of four. A single lookahead generator design serves both levels. In the first level, one instance per group finds the three carries inside the group and reduces the group to one generate and one propagate term. In the second level, one more instance of the same design takes those four group terms and the carry input and finds the carries into groups 1 to 3. The carry output is the whole-word generate OR the whole-word propagate AND the carry input.

Top module: `lookahead_add16`

## Requirements
- R1: Each sum bit equals operand bit A XOR operand bit B XOR the carry into that position, where the carry into bit 0 is the carry input and the carry into bit i+1 is set when at least two of (A[i], B[i], carry into bit i) are set.
- R2: The sum output equals the low 16 bits of A + B + carry input.
- R3: The carry output equals bit 16 of the 17-bit value A + B + carry input.
- R4: The carry into each group boundary (bits 4, 8 and 12) equals bit 4k of the sum of the operands' low 4k bits plus the carry input. At the ports this carry shows as sum[4k] XOR A[4k] XOR B[4k].
- R5: When B is the bitwise inverse of A, so every bit propagates, the sum is 16'hFFFF with carry output 0 if the carry input is 0. It is 16'h0000 with carry output 1 if the carry input is 1.
- R6: A = 16'hFFFF, B = 0 and carry input 1 gives sum 0 and carry output 1, because the carry passes through all sixteen positions.
- R7: A = B = 16'hFFFF gives sum 16'hFFFE or 16'hFFFF (carry input 0 or 1), and the carry output is 1.
- R8: There is no storage. The outputs follow the inputs without waiting for a clock edge. With all inputs at zero, both outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| c_in | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum, low 16 bits |
| c_out | output | 1 | Carry out of bit 15 |

## Verification
The assertions are immediate checks evaluated whenever the inputs change. They assume every input is a known 0 or 1 and that the logic has settled before it is observed. The bench therefore drives only two-state values and waits one time unit after every change before it samples. The stimulus includes a full sweep of 8-bit patterns copied into both bytes, which exercises every carry-in and carry-out pattern at the group boundaries. It also includes directed full-length propagate chains.

// File: rtl/lookahead_add16.sv
module cla4_gen (
  input  logic [3:0] g,
  input  logic [3:0] p,
  input  logic       ci,
  output logic [3:1] c,
  output logic       bg,
  output logic       bp
);
  assign c[1] = g[0] | (p[0] & ci);
  assign c[2] = g[1] | (p[1] & g[0]) | (p[1] & p[0] & ci);
  assign c[3] = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0])
              | (p[2] & p[1] & p[0] & ci);
  assign bg   = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1])
              | (p[3] & p[2] & p[1] & g[0]);
  assign bp   = &p;
endmodule

module lookahead_add16 #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             c_in,
  output logic [WIDTH-1:0] sum_o,
  output logic             c_out
);
  localparam int GW   = 4;
  localparam int NGRP = WIDTH / GW;

  logic [WIDTH-1:0] bit_g, bit_p, bit_c;
  logic [NGRP-1:0]  grp_g, grp_p;
  logic [NGRP-1:0]  grp_cin;
  logic [NGRP-1:1]  top_c;
  logic             all_g, all_p;

  assign bit_g = a_i & b_i;
  assign bit_p = a_i ^ b_i;

  cla4_gen top_u (
    .g (grp_g),
    .p (grp_p),
    .ci(c_in),
    .c (top_c),
    .bg(all_g),
    .bp(all_p)
  );

  assign grp_cin = {top_c, c_in};

  for (genvar k = 0; k < NGRP; k++) begin : g_grp
    logic [3:1] inner_c;
    cla4_gen grp_u (
      .g (bit_g[k*GW +: GW]),
      .p (bit_p[k*GW +: GW]),
      .ci(grp_cin[k]),
      .c (inner_c),
      .bg(grp_g[k]),
      .bp(grp_p[k])
    );
    assign bit_c[k*GW +: GW] = {inner_c, grp_cin[k]};
  end

  assign sum_o = bit_p ^ bit_c;
  assign c_out = all_g | (all_p & c_in);
endmodule

module lookahead_add16_chk (
  input logic [15:0] a_i,
  input logic [15:0] b_i,
  input logic        c_in,
  input logic [15:0] sum_o,
  input logic        c_out,
  input logic [3:0]  grp_cin
);
  logic [16:0] full;
  assign full = {1'b0, a_i} + {1'b0, b_i} + {16'd0, c_in};

  always_comb begin
    assert_sum_R2: assert (sum_o == full[15:0]);
    assert_cout_R3: assert (c_out == full[16]);
    assert_grp1_R4: assert (grp_cin[1] == (({1'b0, a_i[3:0]} + {1'b0, b_i[3:0]} + {4'd0, c_in}) >> 4));
    assert_grp2_R4: assert (grp_cin[2] == (({1'b0, a_i[7:0]} + {1'b0, b_i[7:0]} + {8'd0, c_in}) >> 8));
    assert_grp3_R4: assert (grp_cin[3] == (({1'b0, a_i[11:0]} + {1'b0, b_i[11:0]} + {12'd0, c_in}) >> 12));
    if ((a_i ^ b_i) == 16'hFFFF)
      assert_chain_R5: assert (c_out == c_in && sum_o == {16{~c_in}});
    if (a_i == 16'hFFFF && b_i == 16'hFFFF)
      assert_max_R7: assert (c_out);
  end
endmodule

bind lookahead_add16 lookahead_add16_chk chk_i (
  .a_i    (a_i),
  .b_i    (b_i),
  .c_in   (c_in),
  .sum_o  (sum_o),
  .c_out  (c_out),
  .grp_cin(grp_cin)
);

// File: tb/lookahead_add16_tb.sv
module lookahead_add16_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] a, b, s;
  logic        ci, co;
  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  lookahead_add16 dut_i (.a_i(a), .b_i(b), .c_in(ci), .sum_o(s), .c_out(co));

  task automatic report(string req, bit ok, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s a=%h b=%h ci=%0d actual=%h expected=%h", req, a, b, ci, act, exp);
    end
  endtask

  task automatic apply(logic [15:0] av, logic [15:0] bv, logic cv);
    logic [31:0] tot;
    logic [15:0] rip;
    logic        c;
    a = av; b = bv; ci = cv;
    #1;
    tot = {16'd0, av} + {16'd0, bv} + {31'd0, cv};
    report("R2", s == tot[15:0], {16'd0, s}, {16'd0, tot[15:0]});
    report("R3", co == tot[16], {31'd0, co}, {31'd0, tot[16]});
    c = cv;
    for (int i = 0; i < 16; i++) begin
      rip[i] = c;
      c = (av[i] & bv[i]) | (av[i] & c) | (bv[i] & c);
    end
    report("R1", (s ^ av ^ bv) == rip, {16'd0, s ^ av ^ bv}, {16'd0, rip});
    for (int k = 1; k < 4; k++) begin
      logic [31:0] m, part;
      m = (32'd1 << (4 * k)) - 1;
      part = ({16'd0, av} & m) + ({16'd0, bv} & m) + {31'd0, cv};
      report("R4", (s[4*k] ^ av[4*k] ^ bv[4*k]) == part[4*k],
             {31'd0, s[4*k] ^ av[4*k] ^ bv[4*k]}, {31'd0, part[4*k]});
    end
  endtask

  initial begin
    a = '0; b = '0; ci = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    report("R8", s == 16'h0 && co == 1'b0, {15'd0, co, s}, 32'd0);
    a = 16'h1234; b = 16'h0001;
    #0.5;
    report("R8", s == 16'h1235, {16'd0, s}, 32'h1235);

    for (int x = 0; x < 256; x++)
      for (int y = 0; y < 256; y++)
        for (int c = 0; c < 2; c++)
          apply({x[7:0], x[7:0]}, {y[7:0], y[7:0]}, c[0]);

    for (int i = 0; i < 16; i++) begin
      logic [15:0] r;
      r = 16'(32'h5A3C << i) ^ 16'(i * 16'h1111);
      apply(r, ~r, 1'b0);
      report("R5", s == 16'hFFFF && co == 1'b0, {15'd0, co, s}, 32'h0FFFF);
      apply(r, ~r, 1'b1);
      report("R5", s == 16'h0000 && co == 1'b1, {15'd0, co, s}, 32'h10000);
    end

    apply(16'hFFFF, 16'h0000, 1'b1);
    report("R6", s == 16'h0 && co == 1'b1, {15'd0, co, s}, 32'h10000);
    apply(16'h0000, 16'hFFFF, 1'b1);
    report("R6", s == 16'h0 && co == 1'b1, {15'd0, co, s}, 32'h10000);
    apply(16'hFFFF, 16'hFFFF, 1'b0);
    report("R7", s == 16'hFFFE && co == 1'b1, {15'd0, co, s}, 32'h1FFFE);
    apply(16'hFFFF, 16'hFFFF, 1'b1);
    report("R7", s == 16'hFFFF && co == 1'b1, {15'd0, co, s}, 32'h1FFFF);

    for (int n = 0; n < 4000; n++)
      apply(16'($urandom), 16'($urandom), 1'($urandom));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule